// File: doc/BRIEF.md
# Bounded Descending Stack Pointer Unit

This block owns the stack pointer of a small 8-bit core whose hardware stack sits in a fixed 22-byte window at the very top of a 256-byte memory, from 0xEA up to 0xFF. The core raises a push or a pop request. This covers register saves and restores, and the return addresses of subroutine calls and returns. In the same cycle the unit answers with the memory address and a write or read strobe for the external memory. The pointer then moves on the next clock edge.

The stack grows toward lower addresses from 0xFF. A push stores at the pointer and then moves it down. A pop first moves the pointer up and then reads. A separate full flag lets the last slot at 0xEA be used without the pointer leaving the window. Any illegal request gets a one-cycle error pulse in the same cycle as the request. The illegal requests are a push with all slots used, a pop with nothing stored, and a push and pop raised together. An illegal request leaves the pointer, the flags and the memory untouched.

Top module: `stk_ctrl`

## Requirements
- R1: After reset `sp_o` is 0xFF, `empty_o` is 1, `full_o` is 0, and with no request no strobe or error output is high.
- R2: An accepted push drives `mem_we_o`=1 with `mem_addr_o` equal to the current `sp_o` in the request cycle. After the edge, `sp_o` is one lower, except when it was 0xEA.
- R3: An accepted pop drives `mem_re_o`=1 in the request cycle, with `mem_addr_o` equal to the address of the most recently pushed entry not yet popped. This address is `sp_o`+1, or `sp_o` itself while full. After the edge, `sp_o` is one higher, unless the stack was full.
- R4: The 22nd push writes address 0xEA and sets `full_o`=1, and `sp_o` stays 0xEA.
- R5: A push while `full_o`=1 raises `ovf_o` for that cycle with `mem_we_o`=0, and leaves `sp_o`, `full_o` and `empty_o` unchanged.
- R6: A pop while `empty_o`=1 raises `unf_o` for that cycle with `mem_re_o`=0, and leaves `sp_o` and the flags unchanged.
- R7: Push and pop high in the same cycle raise `conflict_o`, drive no strobe, and change no state.
- R8: A pop from a full stack reads address 0xEA, clears `full_o`, and keeps `sp_o` at 0xEA.
- R9: `sp_o` never leaves the range 0xEA to 0xFF, and at most one of `mem_we_o`, `mem_re_o`, `ovf_o`, `unf_o`, `conflict_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| mem_addr_o | output | 8 | Stack memory address for this cycle |
| mem_we_o | output | 1 | Memory write strobe for an accepted push |
| mem_re_o | output | 1 | Memory read strobe for an accepted pop |
| sp_o | output | 8 | Current stack pointer |
| empty_o | output | 1 | Stack holds no entries |
| full_o | output | 1 | All 22 slots hold entries |
| ovf_o | output | 1 | Overflow error pulse |
| unf_o | output | 1 | Underflow error pulse |
| conflict_o | output | 1 | Simultaneous push and pop error pulse |

## Verification
The hardest state to reach is the boundary where the pointer sits at 0xEA and the full flag alone tells a stack with one free slot from a full one. Getting there takes 22 consecutive accepted pushes. The bench therefore fills the stack completely, pushes into it twice more, then pops one entry and pushes it back to cross the full/not-full edge in both directions. It also drains to empty and pops past it, and tries simultaneous requests at the empty, middle and full levels. A long pseudo-random mix of requests follows, and every cycle is compared against an occupancy count from which the expected addresses are derived arithmetically.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_PUSH,
    OP_POP,
    OP_OVF,
    OP_UNF,
    OP_CLASH
  } stk_op_e;
endpackage

// File: rtl/stk_req_dec.sv
module stk_req_dec
  import stk_pkg::*;
(
  input  logic    push_i,
  input  logic    pop_i,
  input  logic    empty_i,
  input  logic    full_i,
  output stk_op_e op_o
);
  always_comb begin
    op_o = OP_IDLE;
    if (push_i && pop_i)  op_o = OP_CLASH;
    else if (push_i)      op_o = full_i  ? OP_OVF : OP_PUSH;
    else if (pop_i)       op_o = empty_i ? OP_UNF : OP_POP;
  end
endmodule

// File: rtl/stk_ptr_reg.sv
module stk_ptr_reg
  import stk_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] TOP_ADDR = 8'hFF,
  parameter logic [AW-1:0] BOT_ADDR = 8'hEA
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  stk_op_e       op_i,
  output logic [AW-1:0] sp_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [AW-1:0] sp_q, sp_d;
  logic          full_q, full_d;

  always_comb begin
    sp_d   = sp_q;
    full_d = full_q;
    unique case (op_i)
      OP_PUSH: begin
        // last slot: pointer parks at the bottom, full flag marks it used
        if (sp_q == BOT_ADDR) full_d = 1'b1;
        else                  sp_d   = sp_q - AW'(1);
      end
      OP_POP: begin
        if (full_q) full_d = 1'b0;
        else        sp_d   = sp_q + AW'(1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q   <= TOP_ADDR;
      full_q <= 1'b0;
    end else begin
      sp_q   <= sp_d;
      full_q <= full_d;
    end
  end

  assign sp_o    = sp_q;
  assign full_o  = full_q;
  assign empty_o = (sp_q == TOP_ADDR) && !full_q;
endmodule

// File: rtl/stk_addr_gen.sv
module stk_addr_gen
  import stk_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  stk_op_e       op_i,
  input  logic [AW-1:0] sp_i,
  input  logic          full_i,
  output logic [AW-1:0] addr_o,
  output logic          we_o,
  output logic          re_o,
  output logic          ovf_o,
  output logic          unf_o,
  output logic          clash_o
);
  always_comb begin
    addr_o = sp_i;
    if (op_i == OP_POP && !full_i) addr_o = sp_i + AW'(1);
  end

  assign we_o    = (op_i == OP_PUSH);
  assign re_o    = (op_i == OP_POP);
  assign ovf_o   = (op_i == OP_OVF);
  assign unf_o   = (op_i == OP_UNF);
  assign clash_o = (op_i == OP_CLASH);
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] TOP_ADDR = 8'hFF,
  parameter logic [AW-1:0] BOT_ADDR = 8'hEA
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic          mem_re_o,
  output logic [AW-1:0] sp_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          ovf_o,
  output logic          unf_o,
  output logic          conflict_o
);
  stk_op_e op;

  stk_req_dec u_dec (
    .push_i  (push_i),
    .pop_i   (pop_i),
    .empty_i (empty_o),
    .full_i  (full_o),
    .op_o    (op)
  );

  stk_ptr_reg #(.AW(AW), .TOP_ADDR(TOP_ADDR), .BOT_ADDR(BOT_ADDR)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .sp_o    (sp_o),
    .full_o  (full_o),
    .empty_o (empty_o)
  );

  stk_addr_gen #(.AW(AW)) u_addr (
    .op_i    (op),
    .sp_i    (sp_o),
    .full_i  (full_o),
    .addr_o  (mem_addr_o),
    .we_o    (mem_we_o),
    .re_o    (mem_re_o),
    .ovf_o   (ovf_o),
    .unf_o   (unf_o),
    .clash_o (conflict_o)
  );
endmodule

// File: rtl/stk_ctrl_chk.sv
module stk_ctrl_chk #(
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] TOP_ADDR = 8'hFF,
  parameter logic [AW-1:0] BOT_ADDR = 8'hEA
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          push_i,
  input logic          pop_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_we_o,
  input logic          mem_re_o,
  input logic [AW-1:0] sp_o,
  input logic          empty_o,
  input logic          full_o,
  input logic          ovf_o,
  input logic          unf_o,
  input logic          conflict_o
);
  a_r2_push_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o == sp_o) && push_i && !full_o);

  a_r2_push_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && sp_o != BOT_ADDR) |=> sp_o == AW'($past(sp_o) - AW'(1)));

  a_r3_pop_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && !full_o) |=> sp_o == AW'($past(sp_o) + AW'(1)));

  a_r4_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && sp_o == BOT_ADDR) |=> full_o && $stable(sp_o));

  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && full_o) |-> ovf_o && !mem_we_o);

  a_r5_ovf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> $stable(sp_o) && full_o);

  a_r6_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> $stable(sp_o) && empty_o);

  a_r7_clash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |-> conflict_o && !mem_we_o && !mem_re_o);

  a_r7_clash_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |=> $stable(sp_o) && $stable(full_o));

  a_r8_pop_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && full_o) |=> !full_o && sp_o == BOT_ADDR);

  a_r9_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_o >= BOT_ADDR && sp_o <= TOP_ADDR);

  a_r9_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_we_o, mem_re_o, ovf_o, unf_o, conflict_o}));
endmodule

bind stk_ctrl stk_ctrl_chk #(.AW(AW), .TOP_ADDR(TOP_ADDR), .BOT_ADDR(BOT_ADDR)) u_chk (.*);

// File: tb/tb_stk_ctrl.sv
module tb_stk_ctrl;
  localparam int TOP = 'hFF;
  localparam int BOT = 'hEA;
  localparam int DEPTH = TOP - BOT + 1;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       push_i = 1'b0;
  logic       pop_i = 1'b0;
  logic [7:0] mem_addr_o, sp_o;
  logic       mem_we_o, mem_re_o, empty_o, full_o, ovf_o, unf_o, conflict_o;

  int n_run = 0;
  int n_fail = 0;
  int cnt = 0;  // model occupancy
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  stk_ctrl dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    int exp_sp;
    exp_sp = (cnt == DEPTH) ? BOT : TOP - cnt;
    chk(sp_o == 8'(exp_sp), req, sp_o, exp_sp);
    chk(full_o == (cnt == DEPTH), req, full_o, cnt == DEPTH);
    chk(empty_o == (cnt == 0), req, empty_o, cnt == 0);
  endtask

  // drive at negedge, check strobes mid-low-phase, check state after edge
  task automatic do_op(input bit ps, input bit pp);
    @(negedge clk_i);
    push_i = ps;
    pop_i  = pp;
    #1;
    if (ps && pp) begin
      chk(conflict_o && !mem_we_o && !mem_re_o, "R7", {conflict_o, mem_we_o, mem_re_o}, 3'b100);
    end else if (ps) begin
      if (cnt == DEPTH)
        chk(ovf_o && !mem_we_o, "R5", {ovf_o, mem_we_o}, 2'b10);
      else begin
        chk(mem_we_o && !mem_re_o, "R2", {mem_we_o, mem_re_o}, 2'b10);
        chk(mem_addr_o == 8'(TOP - cnt), (cnt == DEPTH - 1) ? "R4" : "R2", mem_addr_o, TOP - cnt);
        cnt++;
      end
    end else if (pp) begin
      if (cnt == 0)
        chk(unf_o && !mem_re_o, "R6", {unf_o, mem_re_o}, 2'b10);
      else begin
        chk(mem_re_o && !mem_we_o, "R3", {mem_re_o, mem_we_o}, 2'b10);
        chk(mem_addr_o == 8'(TOP - cnt + 1), (cnt == DEPTH) ? "R8" : "R3", mem_addr_o, TOP - cnt + 1);
        cnt--;
      end
    end else begin
      chk({mem_we_o, mem_re_o, ovf_o, unf_o, conflict_o} == 5'b0, "R9",
          {mem_we_o, mem_re_o, ovf_o, unf_o, conflict_o}, 0);
    end
    @(posedge clk_i);
    #1;
    push_i = 1'b0;
    pop_i  = 1'b0;
    chk_state(ps && pp ? "R7" : (ps && cnt == DEPTH) ? "R4" : "R9");
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #7;
    chk(sp_o == 8'hFF && empty_o && !full_o, "R1", sp_o, 'hFF);
    chk({mem_we_o, mem_re_o, ovf_o, unf_o, conflict_o} == 5'b0, "R1",
        {mem_we_o, mem_re_o, ovf_o, unf_o, conflict_o}, 0);
    rst_ni = 1'b1;
    do_op(0, 0);
    do_op(0, 1);                                    // R6 underflow at empty
    do_op(1, 1);                                    // R7 at empty
    for (int i = 0; i < DEPTH; i++) do_op(1, 0);    // R2, R4 fill
    do_op(1, 0);                                    // R5
    do_op(1, 0);
    do_op(1, 1);                                    // R7 at full
    do_op(0, 1);                                    // R8
    do_op(1, 0);                                    // refill last slot
    for (int i = 0; i < 10; i++) do_op(0, 1);
    do_op(1, 1);                                    // R7 mid
    for (int i = 0; i < DEPTH; i++) do_op(0, 1);    // R3 drain, R6
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      do_op(r < 5 || r == 9, r >= 5);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule